// File: doc/BRIEF.md
# SDLC Loop Station Repeater Controller

This block attaches a secondary station to a serial SDLC ring. It sits between the bit-serial receive line and the bit-serial transmit line. One clock enable per bit time drives it. It decides what the transmit line carries. There are three choices: the receive line passed straight through, the receive line delayed by one bit, or the output of the local frame generator. Two control inputs steer it: loop enable and go-active-on-poll. Four status outputs report its progress: on-loop, loop-sending, break/abort and hunt.

The station joins the ring in stages. While it is being prepared, the receive line passes straight through. Once go-active-on-poll is raised, a run of seven ones inserts the one-bit repeater delay and the station is on the loop. A received flag and then a received end-of-poll pattern qualify the station to answer polls. After that, an end-of-poll that arrives while go-active-on-poll is set is rewritten on the fly into a flag. The local transmitter then drives the line. It sends flag fill, or the serialized frame bits it is offered through a valid/last/take handshake, and a closing flag. After that it returns to the delay path or keeps filling with flags. The station leaves the ring only at a frame boundary or at a poll boundary. Zero insertion, CRC and byte buffering are outside this block. The frame bits it is offered are already stuffed.

Top module: `sdlc_ring_attach`

## Requirements
- R1: After reset, on_loop, loop_sending, brk_abort and hunt are 0, and tx_bit equals rx_bit combinationally (direct path).
- R2: While loop_en is 1 and go_active is 0, tx_bit follows rx_bit combinationally, and no amount of received ones raises on_loop or brk_abort.
- R3: With loop_en and go_active at 1, the bit time that completes a run of seven consecutive received ones sets on_loop, brk_abort and hunt. From then on, tx_bit is rx_bit as sampled at the previous bit time (one-bit delay).
- R4: brk_abort clears at the first bit time that samples a received 0. hunt clears at the bit time that completes a received flag, 01111110 in arrival order.
- R5: While hunt is still set after joining, a received end-of-poll (0 followed by seven 1s) is only repeated. A flag must be received first, and then an end-of-poll, before the station may answer.
- R6: Once qualified, an end-of-poll received with go_active at 1 has its last 1 replaced by 0 on tx_bit, so that a flag goes out. loop_sending, brk_abort and hunt are set in that bit time. With go_active at 0, the end-of-poll is repeated unchanged and the station stays on the delay path.
- R7: If txd_valid is 1 right after the converted flag, the frame bits go out in the following bit times, one per bit time. txd_take pulses with each bit consumed. The bit marked txd_last is followed by the closing flag.
- R8: With no data offered, whole flags (01111110) are sent back to back after the converted flag. Data starts only at a flag boundary.
- R9: If go_active is 0 when a frame's closing flag ends, loop_sending clears in the next bit time and tx_bit returns to the one-bit delay path.
- R10: If go_active is still 1 when a closing flag ends and no data is offered, further flags are sent.
- R11: Clearing loop_en before the station is on the loop, or while it is hunting after joining, returns it to the direct path at the next bit time, with on_loop and hunt at 0.
- R12: Clearing loop_en while the station is repeating on the delay path and no longer hunting keeps the delay path until the next received end-of-poll completes. Only then does on_loop clear and the direct path return.
- R13: Clearing loop_en while a frame is being sent lets the frame finish, followed by its closing flag and seven 1s (an end-of-poll sharing the flag's final 0). Only then does the station go to the direct path with on_loop at 0.
- R14: No state or status changes on clock edges where bit_en is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | One-cycle pulse per bit time |
| rx_bit | input | 1 | Serial receive line |
| tx_bit | output | 1 | Serial transmit line |
| loop_en | input | 1 | Loop mode enable |
| go_active | input | 1 | Go-active-on-poll control |
| txd_valid | input | 1 | Local frame bit offered |
| txd_bit | input | 1 | Local frame bit value (already zero-stuffed) |
| txd_last | input | 1 | Offered bit is the last of its frame |
| txd_take | output | 1 | Offered bit consumed in this bit time |
| on_loop | output | 1 | Station has inserted its repeater delay |
| loop_sending | output | 1 | Local transmitter owns the line |
| brk_abort | output | 1 | Seven-ones condition seen, held until a 0 arrives |
| hunt | output | 1 | Receiver is searching for a flag |

## Verification
The hardest situation to reach is a disable request that lands mid-frame. It needs a station that has joined, hunted, seen a flag and an end-of-poll, and answered a poll. Each scenario builds this path from reset with shared tasks: seven ones to join, a flag, an end-of-poll with go_active low, then a second end-of-poll with go_active high. Only then does it inject loop_en low between data bits. It then compares every outgoing bit against the expected data, flag and seven-ones trailer. The other sending scenarios use the same build-up. They check the exact bit of the poll conversion and of each flag boundary decision.

// File: rtl/sdlc_ring_pkg.sv
// Shared types for the SDLC ring attach block.
// Assumes: used by all modules of sdlc_ring_attach; no logic here.
package sdlc_ring_pkg;

    // Attachment sequence of the station.
    typedef enum logic [2:0] {
        ST_OFF,     // loop disabled, direct path
        ST_ATTACH,  // loop enabled, waiting for go_active
        ST_SEEK,    // waiting for seven ones to join
        ST_HUNT,    // joined, looking for a flag
        ST_QUAL,    // flag seen, waiting for the qualifying end-of-poll
        ST_RING,    // qualified repeater
        ST_SEND     // local transmitter drives the line
    } ring_state_t;

    // Source of the outgoing line.
    typedef enum logic [1:0] {
        PATH_DIRECT,
        PATH_DELAY,
        PATH_LOCAL
    } path_t;

    // Phases of the local frame generator.
    typedef enum logic [2:0] {
        GP_IDLE,
        GP_BND,    // flag just completed, next bit is decided here
        GP_FLAG,
        GP_DATA,
        GP_EOP
    } gen_phase_t;

endpackage

// File: rtl/ring_pattern_detect.sv
// Receive-line pattern detector.
// Keeps the last FLAG_W received bits and a saturating count of
// consecutive ones. Flags three events for the current bit time:
// a completed flag, a completed end-of-poll, and a run of
// FLAG_W-1 (or more) ones. Assumes rx_bit is stable while bit_en is high.
module ring_pattern_detect #(
    parameter int FLAG_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    output logic flag_hit,
    output logic eop_hit,
    output logic run_hit
);
    localparam int RUN_LEN = FLAG_W - 1;
    localparam int CW      = $clog2(RUN_LEN + 1);
    localparam logic [FLAG_W-1:0] FLAG_PAT = {1'b0, {(FLAG_W-2){1'b1}}, 1'b0};
    localparam logic [FLAG_W-1:0] EOP_PAT  = {1'b0, {(FLAG_W-1){1'b1}}};

    logic [FLAG_W-1:0] hist;
    logic [CW-1:0]     ones;
    logic [FLAG_W-1:0] hist_nxt;

    // Window including the bit sampled in this bit time (oldest at MSB).
    assign hist_nxt = {hist[FLAG_W-2:0], rx_bit};

    // History shift register; reset to ones so no false end-of-poll appears.
    always_ff @(posedge clk) begin
        if (!rst_n)      hist <= '1;
        else if (bit_en) hist <= hist_nxt;
    end

    // Saturating run-of-ones counter, cleared by any received zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                ones <= '0;
        else if (bit_en) begin
            if (!rx_bit)           ones <= '0;
            else if (ones != CW'(RUN_LEN)) ones <= ones + 1'b1;
        end
    end

    // Event decode for the current bit time.
    always_comb begin
        flag_hit = bit_en && (hist_nxt == FLAG_PAT);
        eop_hit  = bit_en && (hist_nxt == EOP_PAT);
        run_hit  = bit_en && rx_bit && (ones >= CW'(RUN_LEN - 1));
    end

endmodule

// File: rtl/ring_local_gen.sv
// Local frame generator for the ring station.
// Started by the sequencer on a poll conversion with a 0 already on the
// line (the closing zero of the converted flag). At every flag boundary
// it either ends an end-of-poll on request, starts offered data, keeps
// filling with flags while go_active is set, or hands the line back.
// Assumes offered bits are already zero-stuffed.
module ring_local_gen #(
    parameter int FLAG_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic start,
    input  logic go_active,
    input  logic leave_req,
    input  logic txd_valid,
    input  logic txd_bit,
    input  logic txd_last,
    output logic gen_bit,
    output logic busy,
    output logic done,
    output logic take
);
    import sdlc_ring_pkg::*;

    localparam int RUN_LEN = FLAG_W - 1;
    localparam int IW      = $clog2(FLAG_W);

    gen_phase_t    phase, phase_nxt;
    logic [IW-1:0] idx, idx_nxt;
    logic          out_q, out_nxt;
    logic          flag_bit;

    // Flag bit for the current position: zeros at both ends.
    assign flag_bit = !((idx == '0) || (idx == IW'(FLAG_W - 1)));

    // Next-bit decision for each generator phase.
    always_comb begin
        phase_nxt = phase;
        idx_nxt   = idx;
        out_nxt   = out_q;
        take      = 1'b0;
        done      = 1'b0;
        if (bit_en) begin
            case (phase)
                GP_IDLE: begin
                    if (start) begin
                        out_nxt   = 1'b0;
                        phase_nxt = GP_BND;
                    end
                end
                GP_BND: begin
                    if (leave_req) begin
                        out_nxt   = 1'b1;
                        idx_nxt   = IW'(1);
                        phase_nxt = GP_EOP;
                    end else if (txd_valid) begin
                        out_nxt   = txd_bit;
                        take      = 1'b1;
                        idx_nxt   = '0;
                        phase_nxt = txd_last ? GP_FLAG : GP_DATA;
                    end else if (go_active) begin
                        out_nxt   = 1'b0;
                        idx_nxt   = IW'(1);
                        phase_nxt = GP_FLAG;
                    end else begin
                        out_nxt   = 1'b1;
                        done      = 1'b1;
                        phase_nxt = GP_IDLE;
                    end
                end
                GP_DATA: begin
                    if (txd_valid) begin
                        out_nxt = txd_bit;
                        take    = 1'b1;
                        if (txd_last) begin
                            idx_nxt   = '0;
                            phase_nxt = GP_FLAG;
                        end
                    end else begin
                        out_nxt   = 1'b0;
                        idx_nxt   = IW'(1);
                        phase_nxt = GP_FLAG;
                    end
                end
                GP_FLAG: begin
                    out_nxt = flag_bit;
                    if (idx == IW'(FLAG_W - 1)) phase_nxt = GP_BND;
                    else                        idx_nxt   = idx + 1'b1;
                end
                GP_EOP: begin
                    out_nxt = 1'b1;
                    if (idx == IW'(RUN_LEN)) begin
                        done      = 1'b1;
                        phase_nxt = GP_IDLE;
                    end else begin
                        idx_nxt = idx + 1'b1;
                    end
                end
                default: phase_nxt = GP_IDLE;
            endcase
        end
    end

    // Generator registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= GP_IDLE;
            idx   <= '0;
            out_q <= 1'b1;
        end else begin
            phase <= phase_nxt;
            idx   <= idx_nxt;
            out_q <= out_nxt;
        end
    end

    assign gen_bit = out_q;
    assign busy    = (phase != GP_IDLE);

endmodule

// File: rtl/ring_seq_ctrl.sv
// Attachment sequencer: joins the ring in stages, qualifies for polls,
// converts a poll into a transmit opportunity and leaves the ring only
// at safe boundaries. Also holds the break/abort and hunt status bits.
// Assumes the detector events are already qualified with bit_en.
module ring_seq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    input  logic loop_en,
    input  logic go_active,
    input  logic flag_hit,
    input  logic eop_hit,
    input  logic run_hit,
    input  logic gen_done,
    output sdlc_ring_pkg::path_t path_sel,
    output logic gen_start,
    output logic on_loop,
    output logic loop_sending,
    output logic brk_abort,
    output logic hunt
);
    import sdlc_ring_pkg::*;

    ring_state_t st, st_nxt;
    logic        start_c;
    logic        set_ev;

    // Next attachment state and status events for this bit time.
    always_comb begin
        st_nxt  = st;
        start_c = 1'b0;
        set_ev  = 1'b0;
        case (st)
            ST_OFF:    if (loop_en) st_nxt = ST_ATTACH;
            ST_ATTACH: begin
                if (!loop_en)       st_nxt = ST_OFF;
                else if (go_active) st_nxt = ST_SEEK;
            end
            ST_SEEK: begin
                if (!loop_en)        st_nxt = ST_OFF;
                else if (!go_active) st_nxt = ST_ATTACH;
                else if (run_hit) begin
                    st_nxt = ST_HUNT;
                    set_ev = 1'b1;
                end
            end
            ST_HUNT: begin
                if (!loop_en)      st_nxt = ST_OFF;
                else if (flag_hit) st_nxt = ST_QUAL;
            end
            ST_QUAL, ST_RING: begin
                if (eop_hit) begin
                    if (!loop_en) st_nxt = ST_OFF;
                    else if (go_active) begin
                        st_nxt  = ST_SEND;
                        start_c = 1'b1;
                        set_ev  = 1'b1;
                    end else begin
                        st_nxt = ST_RING;
                    end
                end
            end
            ST_SEND: if (gen_done) st_nxt = loop_en ? ST_RING : ST_OFF;
            default: st_nxt = ST_OFF;
        endcase
    end

    // Attachment state register, advanced once per bit time.
    always_ff @(posedge clk) begin
        if (!rst_n)      st <= ST_OFF;
        else if (bit_en) st <= st_nxt;
    end

    // Break/abort and hunt status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_abort <= 1'b0;
            hunt      <= 1'b0;
        end else if (bit_en) begin
            if (set_ev)                         brk_abort <= 1'b1;
            else if (!rx_bit || st_nxt == ST_OFF) brk_abort <= 1'b0;
            if (set_ev)                         hunt <= 1'b1;
            else if (flag_hit || st_nxt == ST_OFF) hunt <= 1'b0;
        end
    end

    // Line source and status decode from the attachment state.
    always_comb begin
        case (st)
            ST_HUNT, ST_QUAL, ST_RING: path_sel = PATH_DELAY;
            ST_SEND:                   path_sel = PATH_LOCAL;
            default:                   path_sel = PATH_DIRECT;
        endcase
        on_loop      = (st == ST_HUNT) || (st == ST_QUAL) ||
                       (st == ST_RING) || (st == ST_SEND);
        loop_sending = (st == ST_SEND);
    end

    assign gen_start = bit_en && start_c;

    // R3: seven ones while seeking joins the loop with both status bits up.
    assert_join_on_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && st == ST_SEEK && loop_en && go_active && run_hit)
        |=> (on_loop && hunt && brk_abort));

    // R4: a received zero always leaves break/abort cleared.
    assert_brk_clears_on_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !rx_bit) |=> !brk_abort);

    // R14: nothing moves between bit times.
    assert_hold_without_bit_en_R14: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> ($stable(st) && $stable(brk_abort) && $stable(hunt)));

endmodule

// File: rtl/sdlc_ring_attach.sv
// Top of the SDLC ring station attach logic.
// Holds the one-bit repeater delay and selects the transmit line source
// (direct, delayed, or local generator) as commanded by the sequencer.
// Assumes one bit_en pulse per bit time and rx_bit stable around it.
module sdlc_ring_attach #(
    parameter int FLAG_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rx_bit,
    output logic tx_bit,
    input  logic loop_en,
    input  logic go_active,
    input  logic txd_valid,
    input  logic txd_bit,
    input  logic txd_last,
    output logic txd_take,
    output logic on_loop,
    output logic loop_sending,
    output logic brk_abort,
    output logic hunt
);
    import sdlc_ring_pkg::*;

    logic  rx_q;
    logic  flag_hit, eop_hit, run_hit;
    logic  gen_bit, gen_busy, gen_done, gen_start;
    path_t path_sel;

    // One-bit repeater delay stage.
    always_ff @(posedge clk) begin
        if (!rst_n)      rx_q <= 1'b1;
        else if (bit_en) rx_q <= rx_bit;
    end

    ring_pattern_detect #(.FLAG_W(FLAG_W)) i_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .rx_bit   (rx_bit),
        .flag_hit (flag_hit),
        .eop_hit  (eop_hit),
        .run_hit  (run_hit)
    );

    ring_seq_ctrl i_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_en       (bit_en),
        .rx_bit       (rx_bit),
        .loop_en      (loop_en),
        .go_active    (go_active),
        .flag_hit     (flag_hit),
        .eop_hit      (eop_hit),
        .run_hit      (run_hit),
        .gen_done     (gen_done),
        .path_sel     (path_sel),
        .gen_start    (gen_start),
        .on_loop      (on_loop),
        .loop_sending (loop_sending),
        .brk_abort    (brk_abort),
        .hunt         (hunt)
    );

    ring_local_gen #(.FLAG_W(FLAG_W)) i_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_en    (bit_en),
        .start     (gen_start),
        .go_active (go_active),
        .leave_req (!loop_en),
        .txd_valid (txd_valid),
        .txd_bit   (txd_bit),
        .txd_last  (txd_last),
        .gen_bit   (gen_bit),
        .busy      (gen_busy),
        .done      (gen_done),
        .take      (txd_take)
    );

    // Transmit line source select.
    always_comb begin
        case (path_sel)
            PATH_DIRECT: tx_bit = rx_bit;
            PATH_DELAY:  tx_bit = rx_q;
            default:     tx_bit = gen_bit;
        endcase
    end

    // R6: the local generator is active exactly while the sequencer sends.
    assert_gen_matches_send_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (path_sel == PATH_LOCAL) == gen_busy);

    // R6: the first bit after a poll conversion is the flag's closing zero.
    assert_conversion_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loop_sending) |-> (tx_bit == 1'b0));

    // R7: frame bits are consumed only while the station owns the line.
    assert_take_only_sending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        txd_take |-> loop_sending);

endmodule

// File: tb/test_sdlc_ring_attach.sv
// Directed bench for sdlc_ring_attach: one task per scenario.
module test_sdlc_ring_attach;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic rx = 1'b1;
    logic loop_en = 1'b0;
    logic go = 1'b0;
    logic txd_valid, txd_bit, txd_last;
    logic tx, take, on_loop, sending, brk, hunt;

    int total = 0;
    int bad = 0;
    logic [63:0] dbits = '0;
    int dlen = 0;
    int didx = 0;
    logic dval_en = 1'b0;
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Local frame source model.
    always_comb begin
        txd_valid = dval_en && (didx < dlen);
        txd_bit   = (didx < 64) ? dbits[didx] : 1'b0;
        txd_last  = (didx == dlen - 1);
    end

    sdlc_ring_attach i_sdlc_ring_attach (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx), .tx_bit(tx),
        .loop_en(loop_en), .go_active(go), .txd_valid(txd_valid),
        .txd_bit(txd_bit), .txd_last(txd_last), .txd_take(take),
        .on_loop(on_loop), .loop_sending(sending), .brk_abort(brk), .hunt(hunt)
    );

    function automatic logic flagbit(input int i);
        return !((i == 0) || (i == 7));
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // One bit time: drive rx, pulse bit_en over one rising edge, sample at negedge.
    task automatic step(input logic b);
        logic t;
        rx = b;
        bit_en = 1'b1;
        #1 t = take;
        @(posedge clk);
        @(negedge clk);
        bit_en = 1'b0;
        if (t) didx++;
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) step(1'b1);
    endtask

    task automatic send_flag();
        step(1'b0); send_ones(6); step(1'b0);
    endtask

    task automatic send_eop();
        step(1'b0); send_ones(7);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; loop_en = 1'b0; go = 1'b0; rx = 1'b1; bit_en = 1'b0;
        dval_en = 1'b0; dlen = 0; didx = 0; dbits = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic reach_hunt();
        loop_en = 1'b1; go = 1'b0;
        step(1'b0);
        go = 1'b1;
        send_ones(7);
    endtask

    task automatic reach_ring();
        reach_hunt();
        send_flag();
        go = 1'b0;
        send_eop();
    endtask

    // Sends 0 + seven ones with go high; the last one is converted.
    task automatic poll_now();
        go = 1'b1;
        step(1'b0);
        send_ones(6);
        step(1'b1);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "on_loop", on_loop, 1'b0);
        chk("R1", "loop_sending", sending, 1'b0);
        chk("R1", "brk_abort", brk, 1'b0);
        chk("R1", "hunt", hunt, 1'b0);
        rx = 1'b0; #1 chk("R1", "direct tx low", tx, 1'b0);
        rx = 1'b1; #1 chk("R1", "direct tx high", tx, 1'b1);
    endtask

    task automatic t_attach();
        do_reset();
        loop_en = 1'b1;
        for (int i = 0; i < 12; i++) begin
            step(i % 4 != 0);
            rx = ~rx; #1 chk("R2", "pass-through", tx, rx);
        end
        send_ones(12);
        chk("R2", "no join without go", on_loop, 1'b0);
        chk("R2", "no break without go", brk, 1'b0);
    endtask

    task automatic t_join();
        do_reset();
        loop_en = 1'b1;
        step(1'b0);
        go = 1'b1;
        send_ones(6);
        chk("R3", "six ones no join", on_loop, 1'b0);
        step(1'b1);
        chk("R3", "on_loop", on_loop, 1'b1);
        chk("R3", "brk_abort", brk, 1'b1);
        chk("R3", "hunt", hunt, 1'b1);
        step(1'b0);
        chk("R4", "brk clears on zero", brk, 1'b0);
        rx = 1'b1; #1 chk("R3", "one-bit delay", tx, 1'b0);
        step(1'b1); send_ones(5);
        chk("R4", "hunt before flag end", hunt, 1'b1);
        step(1'b0);
        chk("R4", "hunt clears on flag", hunt, 1'b0);
    endtask

    task automatic t_qualify();
        do_reset();
        reach_hunt();
        send_eop();
        chk("R5", "eop while hunting not answered", sending, 1'b0);
        chk("R5", "still hunting", hunt, 1'b1);
        send_flag();
        send_eop();
        chk("R5", "answered after flag and eop", sending, 1'b1);
    endtask

    task automatic t_poll();
        logic [5:0] d;
        d = 6'b101101;
        do_reset();
        reach_ring();
        chk("R6", "eop without go repeated", sending, 1'b0);
        chk("R6", "eop without go tx", tx, 1'b1);
        dbits = '0; dbits[5:0] = d; dlen = 6; didx = 0; dval_en = 1'b1;
        go = 1'b1;
        step(1'b0);
        for (int i = 0; i < 6; i++) begin
            step(1'b1);
            chk("R6", "poll ones repeated", tx, 1'b1);
        end
        step(1'b1);
        chk("R6", "converted bit", tx, 1'b0);
        chk("R6", "loop_sending", sending, 1'b1);
        chk("R6", "brk_abort", brk, 1'b1);
        chk("R6", "hunt", hunt, 1'b1);
        go = 1'b0;
        for (int i = 0; i < 14; i++) begin
            step(1'b0);
            if (i < 6) chk("R7", "data bit", tx, d[i]);
            else       chk("R9", "closing flag bit", tx, flagbit(i - 6));
        end
        chk("R7", "all bits taken", didx == 6, 1'b1);
        chk("R9", "sending through closing flag", sending, 1'b1);
        step(1'b0);
        chk("R9", "sending cleared", sending, 1'b0);
        chk("R9", "still on loop", on_loop, 1'b1);
        rx = 1'b1; #1 chk("R9", "delay path back", tx, 1'b0);
    endtask

    task automatic t_fill();
        logic [2:0] d;
        d = 3'b011;
        do_reset();
        reach_ring();
        dbits = '0; dbits[2:0] = d; dlen = 3; didx = 0; dval_en = 1'b0;
        poll_now();
        for (int i = 0; i < 16; i++) begin
            step(1'b0);
            chk("R8", "fill flag bit", tx, flagbit(i % 8));
        end
        dval_en = 1'b1;
        for (int i = 0; i < 11; i++) begin
            step(1'b0);
            if (i < 3) chk("R8", "data at boundary", tx, d[i]);
            else       chk("R8", "closing flag bit", tx, flagbit(i - 3));
        end
        for (int i = 0; i < 8; i++) begin
            step(1'b0);
            chk("R10", "extra flag bit", tx, flagbit(i));
        end
        chk("R10", "still sending", sending, 1'b1);
        go = 1'b0;
        step(1'b0);
        chk("R9", "released after go cleared", sending, 1'b0);
    endtask

    task automatic t_leave_direct();
        do_reset();
        reach_hunt();
        loop_en = 1'b0;
        step(1'b1);
        chk("R11", "on_loop off from hunt", on_loop, 1'b0);
        chk("R11", "hunt off", hunt, 1'b0);
        rx = 1'b0; #1 chk("R11", "direct path", tx, 1'b0);
        loop_en = 1'b1; go = 1'b0;
        step(1'b1);
        loop_en = 1'b0;
        step(1'b1);
        rx = 1'b0; #1 chk("R11", "direct after attach exit", tx, 1'b0);
        chk("R11", "on_loop after attach exit", on_loop, 1'b0);
    endtask

    task automatic t_leave_ring();
        do_reset();
        reach_ring();
        loop_en = 1'b0;
        step(1'b0);
        send_ones(6);
        chk("R12", "held until eop", on_loop, 1'b1);
        step(1'b1);
        chk("R12", "off after eop", on_loop, 1'b0);
        rx = 1'b0; #1 chk("R12", "direct path", tx, 1'b0);
    endtask

    task automatic t_leave_send();
        logic [3:0] d;
        d = 4'b1001;
        do_reset();
        reach_ring();
        dbits = '0; dbits[3:0] = d; dlen = 4; didx = 0; dval_en = 1'b1;
        poll_now();
        for (int i = 0; i < 2; i++) begin
            step(1'b0);
            chk("R13", "data bit", tx, d[i]);
        end
        loop_en = 1'b0;
        for (int i = 2; i < 19; i++) begin
            step(1'b0);
            if (i < 4)       chk("R13", "data bit after disable", tx, d[i]);
            else if (i < 12) chk("R13", "closing flag bit", tx, flagbit(i - 4));
            else             chk("R13", "trailing eop one", tx, 1'b1);
        end
        chk("R13", "still on loop", on_loop, 1'b1);
        step(1'b0);
        chk("R13", "off loop", on_loop, 1'b0);
        chk("R13", "not sending", sending, 1'b0);
        rx = 1'b1; #1 chk("R13", "direct path", tx, 1'b1);
    endtask

    task automatic t_gate();
        do_reset();
        loop_en = 1'b1;
        step(1'b0);
        go = 1'b1;
        step(1'b1);
        rx = 1'b1;
        repeat (20) @(negedge clk);
        chk("R14", "no join without bit_en", on_loop, 1'b0);
        send_ones(5);
        chk("R14", "ones counted only on bit_en", on_loop, 1'b0);
        step(1'b1);
        chk("R14", "join on seventh counted one", on_loop, 1'b1);
    endtask

    initial begin
        t_reset();
        t_attach();
        t_join();
        t_qualify();
        t_poll();
        t_fill();
        t_leave_direct();
        t_leave_ring();
        t_leave_send();
        t_gate();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule